// File: doc/BRIEF.md
# Time-of-Day Alarm Interrupt Unit

This unit holds a seconds, a minutes and an hours alarm value and watches the running time counters of a clock/calendar. Whenever the counters take a new value, either on the once-per-second tick or on a load by software, and all three fields equal the stored alarm values, an alarm event occurs. Each event sets a sticky flag in a read-only status register. The active-low interrupt pin is pulled low only if the alarm enable bit in a read-write control register is set.

Software reaches the unit through a small synchronous register port. Reads return data one cycle after the request. A read of the status register clears the flag and releases the pin. A common sequence is to clear the enable bit before loading new time values, so that a load that happens to equal the alarm records the event in the flag but cannot pull the pin low.

Top module: `alm_intr_unit`

## Requirements
- R1: After reset the three alarm values, the enable bit and the flag are zero, `alm_int_n` is 1 and `reg_rdata` is 0.
- R2: A write to address 0 (seconds), 1 (minutes) or 2 (hours) stores the 8-bit value, and a later read of that address returns it.
- R3: Address 3 is the control register. Bit 0 is the alarm enable, and it reads back in bit 0. Bits 7:1 read as 0. Addresses 5 to 7 read as 0.
- R4: Address 4 is the status register, with the alarm flag in bit 0 and bits 7:1 reading 0. Writes to it change nothing.
- R5: An alarm event occurs in a cycle where `tc_tick` or `tc_load` is high and all three time inputs equal the alarm values. The flag reads 1 from the next cycle on.
- R6: If any one of the three fields differs on a tick, no event occurs.
- R7: `alm_int_n` goes low in the cycle after an event only if the enable bit is 1. With enable 0, an event (for example on a load) sets the flag and leaves the pin high.
- R8: Equality without a tick or a load produces no event, however long it lasts.
- R9: A status read returns the flag, then clears it and releases `alm_int_n` from the next cycle on.
- R10: Writing alarm values that equal the present time inputs produces no event.
- R11: If an event and a status read fall in the same cycle, the read returns the earlier flag value, and the flag and pin stay set afterwards.
- R12: Writing 0 to the enable bit releases `alm_int_n` in the next cycle and leaves the flag as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tc_sec | input | 8 | Seconds time counter (BCD) |
| tc_min | input | 8 | Minutes time counter (BCD) |
| tc_hour | input | 8 | Hours time counter, including format bits |
| tc_tick | input | 1 | One-cycle pulse: counters advanced this cycle |
| tc_load | input | 1 | One-cycle pulse: counters loaded by software this cycle |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Register read strobe |
| reg_rdata | output | 8 | Read data, valid the cycle after `reg_rd` |
| alm_int_n | output | 1 | Active-low alarm interrupt |

## Verification
The function pair that can collide is the alarm event and the clearing read of the status register. The bench raises `tc_tick` with matching counters in the same cycle as a status read. It then expects the read to return the cleared value, and expects the flag and the low pin to survive, which a second read confirms. A second overlap is also provoked: a control write that clears the enable bit while a request is pending must release the pin without touching the flag.

// File: rtl/alm_pkg.sv
package alm_pkg;
  localparam int ALM_FIELDS = 3;
  localparam int ALM_DW     = 8;
  localparam int ALM_AW     = 3;

  localparam logic [ALM_AW-1:0] ADDR_ASEC = 3'd0;
  localparam logic [ALM_AW-1:0] ADDR_AMIN = 3'd1;
  localparam logic [ALM_AW-1:0] ADDR_AHR  = 3'd2;
  localparam logic [ALM_AW-1:0] ADDR_CTRL = 3'd3;
  localparam logic [ALM_AW-1:0] ADDR_STAT = 3'd4;

  localparam int CTRL_EN_BIT  = 0;
  localparam int STAT_ALM_BIT = 0;

  typedef logic [ALM_FIELDS-1:0][ALM_DW-1:0] alm_vec_t;

  // True when every alarm field equals the matching time field.
  function automatic logic fields_equal(input alm_vec_t alarm, input alm_vec_t now);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < ALM_FIELDS; i++) begin
      if (alarm[i] != now[i]) ok = 1'b0;
    end
    return ok;
  endfunction

  // Places a single bit at a position of an otherwise zero byte.
  function automatic logic [ALM_DW-1:0] bit_at(input logic b, input int pos);
    logic [ALM_DW-1:0] v;
    v = '0;
    v[pos] = b;
    return v;
  endfunction
endpackage

// File: rtl/alm_latch_bank.sv
module alm_latch_bank
  import alm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ALM_AW-1:0] addr,
  input  logic [ALM_DW-1:0] wdata,
  output alm_vec_t          alarm
);
  logic [ALM_FIELDS-1:0] wr_sel;

  genvar gi;
  generate
    for (gi = 0; gi < ALM_FIELDS; gi++) begin : g_field
      assign wr_sel[gi] = wr && (addr == ALM_AW'(gi));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          alarm[gi] <= '0;
        else if (wr_sel[gi]) alarm[gi] <= wdata;
      end

      // R2: a selected write lands in its own field
      a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sel[gi] |=> (alarm[gi] == $past(wdata)));
    end
  endgenerate
endmodule

// File: rtl/alm_match.sv
module alm_match
  import alm_pkg::*;
(
  input  logic     tick,
  input  logic     load,
  input  alm_vec_t alarm,
  input  alm_vec_t now,
  output logic     equal,
  output logic     hit
);
  // Equality alone is not an event: only a counter update qualifies it.
  assign equal = fields_equal(alarm, now);
  assign hit   = (tick || load) && equal;
endmodule

// File: rtl/alm_irq_ctrl.sv
module alm_irq_ctrl
  import alm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic ctrl_wr,
  input  logic ctrl_en_in,
  input  logic st_rd,
  output logic en,
  output logic flag,
  output logic alm_int_n
);
  logic pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en <= 1'b0;
    else if (ctrl_wr) en <= ctrl_en_in;
  end

  // Sticky flag: a new event outranks the clearing read.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag <= 1'b0;
    else if (hit)   flag <= 1'b1;
    else if (st_rd) flag <= 1'b0;
  end

  // Pin request: a disabling write wins, then an enabled event, then a read.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      pending <= 1'b0;
    else if (ctrl_wr && !ctrl_en_in) pending <= 1'b0;
    else if (hit && en)              pending <= 1'b1;
    else if (st_rd)                  pending <= 1'b0;
  end

  assign alm_int_n = ~pending;

  // R7: the pin falls only after an enabled event
  a_r7_pin_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(alm_int_n) |-> $past(hit && en));

  // R9: a read without a new event clears the flag
  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (st_rd && !hit) |=> !flag);

  // R11: an event is never lost to a simultaneous read
  a_r11_hit_beats_read: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag);

  // R12: disabling releases the pin
  a_r12_disable_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !ctrl_en_in) |=> alm_int_n);
endmodule

// File: rtl/alm_intr_unit.sv
module alm_intr_unit
  import alm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ALM_DW-1:0] tc_sec,
  input  logic [ALM_DW-1:0] tc_min,
  input  logic [ALM_DW-1:0] tc_hour,
  input  logic              tc_tick,
  input  logic              tc_load,
  input  logic [ALM_AW-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [ALM_DW-1:0] reg_wdata,
  input  logic              reg_rd,
  output logic [ALM_DW-1:0] reg_rdata,
  output logic              alm_int_n
);
  alm_vec_t alarm;
  alm_vec_t now;
  logic     equal;
  logic     hit;
  logic     en;
  logic     flag;
  logic     ctrl_wr;
  logic     st_rd;
  logic     st_wr;
  logic [ALM_DW-1:0] rd_mux;

  assign now[0] = tc_sec;
  assign now[1] = tc_min;
  assign now[2] = tc_hour;

  assign ctrl_wr = reg_wr && (reg_addr == ADDR_CTRL);
  assign st_rd   = reg_rd && (reg_addr == ADDR_STAT);
  assign st_wr   = reg_wr && (reg_addr == ADDR_STAT);

  alm_latch_bank u_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (reg_wr),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .alarm (alarm)
  );

  alm_match u_match (
    .tick  (tc_tick),
    .load  (tc_load),
    .alarm (alarm),
    .now   (now),
    .equal (equal),
    .hit   (hit)
  );

  alm_irq_ctrl u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit        (hit),
    .ctrl_wr    (ctrl_wr),
    .ctrl_en_in (reg_wdata[CTRL_EN_BIT]),
    .st_rd      (st_rd),
    .en         (en),
    .flag       (flag),
    .alm_int_n  (alm_int_n)
  );

  always_comb begin
    case (reg_addr)
      ADDR_ASEC: rd_mux = alarm[0];
      ADDR_AMIN: rd_mux = alarm[1];
      ADDR_AHR:  rd_mux = alarm[2];
      ADDR_CTRL: rd_mux = bit_at(en, CTRL_EN_BIT);
      ADDR_STAT: rd_mux = bit_at(flag, STAT_ALM_BIT);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  // R8: the flag never rises without a tick or a load
  a_r8_event_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(tc_tick || tc_load));

  // R4: a status write with no event and no read leaves the flag unchanged
  a_r4_status_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && !hit && !st_rd) |=> (flag == $past(flag)));

  // R10: equality with no counter update is not an event
  a_r10_equal_alone_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (equal && !tc_tick && !tc_load && !flag) |=> !flag);
endmodule

// File: tb/alm_intr_unit_test.sv
`timescale 1ns/1ps
module alm_intr_unit_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] tc_sec = '0, tc_min = '0, tc_hour = '0;
  logic       tc_tick = 1'b0, tc_load = 1'b0;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       alm_int_n;

  int compared = 0;
  int mismatched = 0;
  logic rd_q = 1'b0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  alm_intr_unit uut (
    .clk(clk), .rst_n(rst_n), .tc_sec(tc_sec), .tc_min(tc_min), .tc_hour(tc_hour),
    .tc_tick(tc_tick), .tc_load(tc_load), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata), .alm_int_n(alm_int_n)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Monitor: notes each read at the edge, compares at the following falling edge.
  always @(posedge clk) rd_q <= reg_rd;
  always @(negedge clk) begin
    if (rd_q) begin
      if (exp_q.size() == 0) check(1'b0, "scoreboard empty", 0, 1);
      else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(reg_rdata == e, t, reg_rdata, e);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
    reg_addr = a; reg_rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic set_time(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                          input logic as_tick);
    tc_sec = s; tc_min = m; tc_hour = h;
    if (as_tick) tc_tick = 1'b1; else tc_load = 1'b1;
    @(negedge clk);
    tc_tick = 1'b0; tc_load = 1'b0;
  endtask

  task automatic pin(input logic e, input string tag);
    check(alm_int_n == e, tag, alm_int_n, e);
  endtask

  initial begin
    #(8 * 200000);
    check(1'b0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    pin(1'b1, "R1 pin after reset");
    check(reg_rdata == 8'h00, "R1 rdata after reset", reg_rdata, 0);
    for (int a = 0; a < 5; a++) rd(3'(a), 8'h00, "R1 register after reset");

    // R2 latches, R3 control and unused addresses
    wr(3'd0, 8'h30); wr(3'd1, 8'h15); wr(3'd2, 8'h88);
    rd(3'd0, 8'h30, "R2 seconds"); rd(3'd1, 8'h15, "R2 minutes"); rd(3'd2, 8'h88, "R2 hours");
    wr(3'd3, 8'hFF);
    rd(3'd3, 8'h01, "R3 control readback");
    rd(3'd5, 8'h00, "R3 unused address");
    rd(3'd7, 8'h00, "R3 unused address 7");

    // R4 status is read-only
    wr(3'd4, 8'hFF);
    rd(3'd4, 8'h00, "R4 status write ignored");

    // R6 partial matches
    set_time(8'h29, 8'h15, 8'h88, 1'b1); pin(1'b1, "R6 seconds differ");
    set_time(8'h30, 8'h14, 8'h88, 1'b1); pin(1'b1, "R6 minutes differ");
    set_time(8'h30, 8'h15, 8'h08, 1'b1); pin(1'b1, "R6 hour format bit differs");
    rd(3'd4, 8'h00, "R6 no flag after partial matches");

    // R5, R7, R9 full match with enable
    set_time(8'h30, 8'h15, 8'h88, 1'b1);
    pin(1'b0, "R7 pin low after enabled match");
    rd(3'd4, 8'h01, "R5 flag after match");
    pin(1'b1, "R9 pin released by status read");
    rd(3'd4, 8'h00, "R9 flag cleared by read");

    // R8 held equality without tick
    repeat (10) @(negedge clk);
    pin(1'b1, "R8 no event without tick");
    rd(3'd4, 8'h00, "R8 flag stays clear");

    // R10 writing latches equal to present time
    wr(3'd0, 8'h30); wr(3'd2, 8'h88);
    pin(1'b1, "R10 latch write no interrupt");
    rd(3'd4, 8'h00, "R10 latch write no flag");

    // R7 disabled load: flag only
    wr(3'd3, 8'h00);
    set_time(8'h30, 8'h15, 8'h88, 1'b0);
    pin(1'b1, "R7 pin held with enable clear");
    rd(3'd4, 8'h01, "R7 flag recorded while disabled");

    // R12 disabling releases pin, flag kept
    wr(3'd3, 8'h01);
    set_time(8'h30, 8'h15, 8'h88, 1'b1);
    pin(1'b0, "R12 pin low before disable");
    wr(3'd3, 8'h00);
    pin(1'b1, "R12 pin released by disable");
    rd(3'd4, 8'h01, "R12 flag unaffected by disable");

    // R11 event and status read in the same cycle
    wr(3'd3, 8'h01);
    tc_tick = 1'b1;
    rd(3'd4, 8'h00, "R11 read returns prior flag");
    tc_tick = 1'b0;
    pin(1'b0, "R11 pin survives collision");
    // R4 write to status while flag set has no effect
    wr(3'd4, 8'h00);
    pin(1'b0, "R4 status write keeps pin");
    rd(3'd4, 8'h01, "R11 flag survives collision");
    pin(1'b1, "R9 final release");

    // R5 new alarm time reached later by tick
    wr(3'd0, 8'h31);
    set_time(8'h31, 8'h15, 8'h88, 1'b1);
    pin(1'b0, "R5 match on next second");
    rd(3'd4, 8'h01, "R5 flag on next second");

    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule